// File: doc/BRIEF.md
# Privilege-Gated Event Counter

This block is a 32-bit up-counter for performance monitoring. Each cycle it may add one for a single event line. A separate control register qualifies that line with an enable and can clear the count with a one-cycle zero pulse. Counting stops while the core is halted for debug. It also stops when the current mode may not be observed by non-invasive debug.

Software reaches the block through a coprocessor-style port with two registers. The count register holds the full count value. The status register holds a sticky wrap flag in bit 0, and writing 1 to that bit clears it. Privileged code can always access both registers. User code can access them only when a validation bit grants it. Otherwise the access is refused with an undefined-instruction fault pulse and has no effect.

The count is one copy shared by both security worlds. When the count wraps, the flag is set, and the flag drives an interrupt line through an enable input.

Top module: `perf_event_counter`

## Requirements
- R1: After synchronous reset the count, the wrap flag, `acc_rdata`, `undef_fault` and `irq` are all 0.
- R2: While `cnt_en`=1, `dbg_halt`=0 and `obs_allow`=1, each cycle with `evt_pulse`=1 adds exactly one to the count. Cycles without a pulse, or with `cnt_en`=0, leave the count unchanged.
- R3: While `dbg_halt`=1, event pulses do not change the count.
- R4: While `obs_allow`=0, event pulses do not change the count.
- R5: When `mode_priv`=1 an access never faults. A read (`acc_wr`=0) with `acc_sel`=0 puts the count in `acc_rdata` on the edge that samples the request, and one with `acc_sel`=1 puts the wrap flag in bit 0 with the other bits at 0. A write with `acc_sel`=0 loads `acc_wdata` into the count.
- R6: In user mode (`mode_priv`=0) an access behaves as in R5 when `user_ok`=1. When `user_ok`=0, `undef_fault` is 1 for the one cycle after the request, and the count and `acc_rdata` keep their values.
- R7: An increment from all ones wraps the count to 0 and sets the wrap flag. The flag stays set until software clears it.
- R8: An allowed write to the status register (`acc_sel`=1) with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R9: `irq` equals the wrap flag ANDed with the value `irq_en` had at the previous clock edge.
- R10: An allowed count write in the same cycle as a qualified event loads the written value, and the increment is lost.
- R11: `cnt_zero` clears the count even when a count write and a qualified event occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 1 | One-cycle occurrence of the selected event |
| cnt_en | input | 1 | Counter enable from the control register |
| cnt_zero | input | 1 | Clear-count pulse from the control register |
| mode_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| user_ok | input | 1 | Validation bit that permits user-mode access |
| dbg_halt | input | 1 | Core is in debug state |
| obs_allow | input | 1 | Non-invasive debug is permitted in the current mode |
| acc_req | input | 1 | Register access request, one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = count register, 1 = status register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, updated by allowed reads |
| undef_fault | output | 1 | Refused access, undefined-instruction fault pulse |
| irq_en | input | 1 | Interrupt enable for the wrap flag |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is driven through all 16 combinations of pulse, enable, debug halt and observation permit. Starting from a distinct preloaded count each time, this tells apart a gated event, a counted event and an idle cycle.

The access path is swept over mode, validation bit and direction. A status read placed just before each access puts a known 0 in the read register, so a refused read can be told apart from an allowed one, and a refused write from an allowed one.

Wrap, clear, interrupt enable and the three-way priority between zero pulse, write and increment are each driven from an all-ones preload. Expected results are worked out arithmetically.

// File: rtl/pec_pkg.sv
package pec_pkg;
  // register selector values on the access port
  typedef enum logic {
    REG_COUNT  = 1'b0,
    REG_STATUS = 1'b1
  } pec_reg_e;

  // position of the sticky wrap flag inside the status register
  localparam int STS_WRAP_BIT = 0;
endpackage

// File: rtl/pec_access_gate.sv
module pec_access_gate
  import pec_pkg::*;
(
  input  logic acc_req,
  input  logic acc_wr,
  input  logic acc_sel,
  input  logic mode_priv,
  input  logic user_ok,
  input  logic evt_pulse,
  input  logic cnt_en,
  input  logic dbg_halt,
  input  logic obs_allow,
  output logic acc_bad,
  output logic rd_go,
  output logic wr_cnt,
  output logic wr_sts,
  output logic cnt_step
);
  logic     acc_ok;
  pec_reg_e target;

  always_comb begin
    target   = pec_reg_e'(acc_sel);
    acc_ok   = acc_req && (mode_priv || user_ok);
    acc_bad  = acc_req && !(mode_priv || user_ok);
    rd_go    = acc_ok && !acc_wr;
    wr_cnt   = acc_ok && acc_wr && (target == REG_COUNT);
    wr_sts   = acc_ok && acc_wr && (target == REG_STATUS);
    cnt_step = evt_pulse && cnt_en && !dbg_halt && obs_allow;
  end
endmodule

// File: rtl/pec_count_core.sv
module pec_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // a wrap only counts when the increment really lands
  assign wrap = step && !zero && !wr && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (zero) cnt_q <= '0;
    else if (wr)   cnt_q <= wdata;
    else if (step) cnt_q <= cnt_q + CNT_ONE;
  end
endmodule

// File: rtl/pec_wrap_flag.sv
module pec_wrap_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_q
);
  logic flag_d;

  // set beats clear so no wrap is ever lost
  assign flag_d = set || (flag_q && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d && irq_en;
    end
  end
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_pulse,
  input  logic             cnt_en,
  input  logic             cnt_zero,
  input  logic             mode_priv,
  input  logic             user_ok,
  input  logic             dbg_halt,
  input  logic             obs_allow,
  input  logic             acc_req,
  input  logic             acc_wr,
  input  logic             acc_sel,
  input  logic [CNT_W-1:0] acc_wdata,
  output logic [CNT_W-1:0] acc_rdata,
  output logic             undef_fault,
  input  logic             irq_en,
  output logic             irq
);
  logic             acc_bad, rd_go, wr_cnt, wr_sts, cnt_step;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap, flag_q;
  logic [CNT_W-1:0] sts_word;

  pec_access_gate u_gate (
    .acc_req  (acc_req),
    .acc_wr   (acc_wr),
    .acc_sel  (acc_sel),
    .mode_priv(mode_priv),
    .user_ok  (user_ok),
    .evt_pulse(evt_pulse),
    .cnt_en   (cnt_en),
    .dbg_halt (dbg_halt),
    .obs_allow(obs_allow),
    .acc_bad  (acc_bad),
    .rd_go    (rd_go),
    .wr_cnt   (wr_cnt),
    .wr_sts   (wr_sts),
    .cnt_step (cnt_step)
  );

  pec_count_core #(.CNT_W(CNT_W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .zero (cnt_zero),
    .wr   (wr_cnt),
    .wdata(acc_wdata),
    .step (cnt_step),
    .cnt_q(cnt_q),
    .wrap (wrap)
  );

  pec_wrap_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set   (wrap),
    .clr   (wr_sts && acc_wdata[STS_WRAP_BIT]),
    .irq_en(irq_en),
    .flag_q(flag_q),
    .irq_q (irq)
  );

  always_comb begin
    sts_word               = '0;
    sts_word[STS_WRAP_BIT] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata   <= '0;
      undef_fault <= 1'b0;
    end else begin
      undef_fault <= acc_bad;
      if (rd_go)
        acc_rdata <= (pec_reg_e'(acc_sel) == REG_STATUS) ? sts_word : cnt_q;
    end
  end
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_pulse,
  input logic             cnt_en,
  input logic             cnt_zero,
  input logic             mode_priv,
  input logic             user_ok,
  input logic             dbg_halt,
  input logic             obs_allow,
  input logic             acc_req,
  input logic             acc_wr,
  input logic             acc_sel,
  input logic [CNT_W-1:0] acc_wdata,
  input logic             undef_fault,
  input logic             irq_en,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q
);
  logic cnt_write;
  assign cnt_write = acc_req && acc_wr && !acc_sel && (mode_priv || user_ok);

  p_priv_no_fault_r5: assert property (@(posedge clk) disable iff (rst)
    acc_req && mode_priv |=> !undef_fault);

  p_user_refused_r6: assert property (@(posedge clk) disable iff (rst)
    acc_req && !mode_priv && !user_ok |=> undef_fault);

  p_refused_write_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_wr && !mode_priv && !user_ok && !cnt_zero &&
    !(evt_pulse && cnt_en && !dbg_halt && obs_allow) |=> $stable(cnt_q));

  p_halt_holds_r3: assert property (@(posedge clk) disable iff (rst)
    dbg_halt && !cnt_zero && !cnt_write |=> $stable(cnt_q));

  p_no_observe_holds_r4: assert property (@(posedge clk) disable iff (rst)
    !obs_allow && !cnt_zero && !cnt_write |=> $stable(cnt_q));

  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (rst)
    evt_pulse && cnt_en && !dbg_halt && obs_allow && (cnt_q == {CNT_W{1'b1}}) &&
    !cnt_zero && !cnt_write |=> flag_q && (cnt_q == '0));

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (flag_q && $past(irq_en))));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_write && !cnt_zero |=> cnt_q == $past(acc_wdata));

  p_zero_wins_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_zero |=> cnt_q == '0);
endmodule

bind perf_event_counter pec_checker #(.CNT_W(CNT_W)) u_pec_checker (
  .clk        (clk),
  .rst        (rst),
  .evt_pulse  (evt_pulse),
  .cnt_en     (cnt_en),
  .cnt_zero   (cnt_zero),
  .mode_priv  (mode_priv),
  .user_ok    (user_ok),
  .dbg_halt   (dbg_halt),
  .obs_allow  (obs_allow),
  .acc_req    (acc_req),
  .acc_wr     (acc_wr),
  .acc_sel    (acc_sel),
  .acc_wdata  (acc_wdata),
  .undef_fault(undef_fault),
  .irq_en     (irq_en),
  .irq        (irq),
  .cnt_q      (cnt_q),
  .flag_q     (flag_q)
);

// File: tb/perf_event_counter_bench.sv
module perf_event_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         evt_pulse, cnt_en, cnt_zero, mode_priv, user_ok, dbg_halt, obs_allow;
  logic         acc_req, acc_wr, acc_sel, irq_en;
  logic [W-1:0] acc_wdata;
  logic [W-1:0] acc_rdata;
  logic         undef_fault, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_event_counter #(.CNT_W(W)) u_perf_event_counter (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .cnt_en(cnt_en), .cnt_zero(cnt_zero),
    .mode_priv(mode_priv), .user_ok(user_ok), .dbg_halt(dbg_halt), .obs_allow(obs_allow),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .undef_fault(undef_fault), .irq_en(irq_en), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic priv, input logic uok, input logic wr,
                        input logic sel, input logic [W-1:0] data);
    mode_priv = priv; user_ok = uok; acc_wr = wr; acc_sel = sel; acc_wdata = data;
    acc_req = 1'b1;
    tick();
    acc_req = 1'b0; acc_wr = 1'b0; mode_priv = 1'b1;
  endtask

  task automatic write_count(input logic [W-1:0] v);
    access(1'b1, 1'b0, 1'b1, 1'b0, v);
  endtask

  task automatic read_count(output logic [W-1:0] v);
    access(1'b1, 1'b0, 1'b0, 1'b0, '0);
    v = acc_rdata;
  endtask

  task automatic read_flag(output logic [W-1:0] v);
    access(1'b1, 1'b0, 1'b0, 1'b1, '0);
    v = acc_rdata;
  endtask

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] base;
    rst = 1'b1;
    evt_pulse = 0; cnt_en = 1; cnt_zero = 0; mode_priv = 1; user_ok = 0;
    dbg_halt = 0; obs_allow = 1; acc_req = 0; acc_wr = 0; acc_sel = 0;
    acc_wdata = '0; irq_en = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check("R1 rdata after reset", acc_rdata, '0);
    check("R1 fault after reset", 32'(undef_fault), 0);
    check("R1 irq after reset", 32'(irq), 0);
    read_count(v);  check("R1 count after reset", v, '0);
    read_flag(v);   check("R1 flag after reset", v, '0);

    // counting sweep over pulse, enable, halt, observation permit
    for (int k = 0; k < 16; k++) begin
      base = 32'd100 + 32'(k) * 32'd7;
      write_count(base);
      evt_pulse = k[0]; cnt_en = k[1]; dbg_halt = k[2]; obs_allow = k[3];
      tick();
      evt_pulse = 0; cnt_en = 1; dbg_halt = 0; obs_allow = 1;
      read_count(v);
      if (k[2] && k[0] && k[1])
        check("R3 halted event", v, base);
      else if (!k[3] && k[0] && k[1])
        check("R4 unobserved event", v, base);
      else
        check("R2 event sweep", v, base + 32'(k[0] && k[1] && !k[2] && k[3]));
    end

    // burst with gaps
    write_count(32'd10);
    for (int i = 0; i < 12; i++) begin
      evt_pulse = (i % 3 != 1);
      tick();
    end
    evt_pulse = 0;
    read_count(v); check("R2 burst of 8", v, 32'd18);

    // access sweep over mode, validation bit, direction
    for (int k = 0; k < 8; k++) begin
      logic ok;
      ok = k[0] || k[1];
      write_count(32'h1000 + 32'(k));
      read_flag(v);
      access(k[0], k[1], k[2], 1'b0, 32'hA5A5_0000 + 32'(k));
      check(k[0] ? "R5 fault flag" : "R6 fault flag", 32'(undef_fault), 32'(!ok));
      if (!k[2])
        check(k[0] ? "R5 read data" : "R6 read data", acc_rdata,
              ok ? 32'h1000 + 32'(k) : 32'h0);
      tick();
      check("R6 fault is one pulse", 32'(undef_fault), 0);
      read_count(v);
      check(k[0] ? "R5 count after write" : "R6 count after access", v,
            (ok && k[2]) ? 32'hA5A5_0000 + 32'(k) : 32'h1000 + 32'(k));
    end

    // wrap and interrupt
    irq_en = 1;
    write_count('1);
    evt_pulse = 1; tick(); evt_pulse = 0;
    check("R9 irq on wrap", 32'(irq), 1);
    read_count(v); check("R7 wrap to zero", v, '0);
    read_flag(v);  check("R7 flag set", v, 32'd1);
    irq_en = 0; tick();
    check("R9 irq masked", 32'(irq), 0);
    repeat (3) tick();
    read_flag(v);  check("R7 flag sticky", v, 32'd1);
    access(1'b1, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFE);
    read_flag(v);  check("R8 write 0 keeps flag", v, 32'd1);
    access(1'b0, 1'b0, 1'b1, 1'b1, 32'd1);
    read_flag(v);  check("R6 refused clear keeps flag", v, 32'd1);
    access(1'b0, 1'b1, 1'b1, 1'b1, 32'd1);
    read_flag(v);  check("R8 write 1 clears flag", v, 32'd0);
    write_count('1);
    evt_pulse = 1;
    access(1'b1, 1'b0, 1'b1, 1'b1, 32'd1);
    evt_pulse = 0;
    read_flag(v);  check("R8 wrap beats clear", v, 32'd1);
    access(1'b1, 1'b0, 1'b1, 1'b1, 32'd1);
    write_count('1);
    cnt_zero = 1; tick(); cnt_zero = 0;
    read_flag(v);  check("R11 zero pulse is no wrap", v, 32'd0);

    // priorities
    write_count(32'd40);
    evt_pulse = 1; write_count(32'd5); evt_pulse = 0;
    read_count(v); check("R10 write beats event", v, 32'd5);
    write_count('1);
    evt_pulse = 1; write_count('1); evt_pulse = 0;
    read_flag(v);  check("R10 dropped increment no wrap", v, 32'd0);
    evt_pulse = 1; cnt_zero = 1; write_count(32'd77); evt_pulse = 0; cnt_zero = 0;
    read_count(v); check("R11 zero beats write and event", v, '0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule